// File: doc/BRIEF.md
# Lockable Round-Robin Instruction Translation Buffer

This block caches translations from virtual to physical page numbers for an instruction-fetch path. It holds 32 entries, and any entry can hold any page. Each entry stores a 20-bit virtual page number, a 20-bit physical page number, a 2-bit access-permission code, a 4-bit domain number and a 4-bit attribute code. Pages are 4 KB, so the low 12 address bits pass through unchanged. A lookup arrives on a valid/ready stream and compares its page number against every valid entry in parallel. Its result leaves on a second valid/ready stream.

On a miss the block raises a table-walk request carrying the missing page number. It then waits for a descriptor on a fill stream. The descriptor is written into a victim entry and returned as the response to the stalled lookup. Victims are taken in round-robin order, and only from entries that are not locked.

A lock boundary register holds a value N. It pins entries 0..N-1, and it saturates at 31, so the last entry is always replaceable. When the victim pointer passes the last entry it wraps back to N. A single-cycle invalidate-all pulse drops every unlocked entry and keeps the locked ones.

Top module: `rr_tlb`

## Requirements
- R1: After reset all entries are invalid, the lock boundary is 0, the victim pointer is 0, `lk_ready` is 1, and `miss`, `rsp_valid`, `walk_req_valid` and `fill_ready` are 0.
- R2: When a lookup is accepted and its VPN (`lk_vaddr[31:12]`) matches a valid entry, the response appears in the next cycle with `rsp_hit`=1. `rsp_paddr` is {stored PPN, `lk_vaddr[11:0]`}, and the permission, domain and attribute fields come from that entry.
- R3: When an accepted lookup matches no valid entry, `miss` and `walk_req_valid` rise in the next cycle with `walk_req_vpn` equal to the missing VPN. Both hold steady until `walk_req_ready` is seen. `lk_ready` stays 0 for as long as `miss` is 1.
- R4: `fill_ready` is 1 only in the cycles after the walk request has been taken. A fill accepted in that state produces a response in the next cycle with `rsp_hit`=0 and the fill's fields, and `miss` falls in that same cycle. The translation is installed, so the next lookup of that VPN hits.
- R5: Each fill advances the victim pointer by one. Entries are refilled in order from the lock boundary up to entry 31, and the pointer then wraps back to the lock boundary. With no lock, the 33rd distinct fill evicts the 1st.
- R6: A `lock_wr` pulse with value N locks entries 0..N-1 from the next cycle on. A locked entry is never chosen as a victim. A pointer lying below N moves up to N.
- R7: A lock value above 31 is clamped to 31. Every fill then goes to entry 31.
- R8: An `inv_all` pulse clears the valid bit of every unlocked entry and leaves the locked entries able to hit.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, all response outputs hold steady and `lk_ready` is 0. `lk_ready` is 1 only when the controller is idle and the response slot is empty or being drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_vaddr | input | 32 | Virtual fetch address |
| rsp_valid | output | 1 | Translation response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_hit | output | 1 | 1: served from the buffer, 0: served by a fill |
| rsp_paddr | output | 32 | Physical address |
| rsp_ap | output | 2 | Access-permission code |
| rsp_dom | output | 4 | Domain number |
| rsp_attr | output | 4 | Cache attribute code |
| miss | output | 1 | A walk is outstanding |
| walk_req_valid | output | 1 | Table-walk request valid |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_req_vpn | output | 20 | Page number to walk |
| fill_valid | input | 1 | Descriptor fill valid |
| fill_ready | output | 1 | Block accepts the fill |
| fill_ppn | input | 20 | Physical page number of the fill |
| fill_ap | input | 2 | Permission code of the fill |
| fill_dom | input | 4 | Domain number of the fill |
| fill_attr | input | 4 | Attribute code of the fill |
| lock_wr | input | 1 | Load the lock boundary |
| lock_val | input | 6 | New lock boundary, saturated at 31 |
| inv_all | input | 1 | Invalidate all unlocked entries |

## Verification
Every result is due exactly one rising edge after the handshake that causes it. A hit response follows the accepted lookup. The walk request follows the accepted miss. `fill_ready` follows the taken walk request. The fill response, with `miss` low, follows the accepted fill. Lock and invalidate pulses take effect on the edge that samples them. The bench drives each input at a falling edge, waits one falling edge per register on the path, and samples the outputs there, half a period clear of any active edge. Held states such as a stalled walk request or a blocked response are sampled again on every falling edge they last.

// File: rtl/rr_tlb_pkg.sv
package rr_tlb_pkg;
  localparam int VA_W     = 32;
  localparam int PG_OFS_W = 12;
  localparam int VPN_W    = VA_W - PG_OFS_W;
  localparam int PPN_W    = 20;
  localparam int PA_W     = PPN_W + PG_OFS_W;
  localparam int AP_W     = 2;
  localparam int DOM_W    = 4;
  localparam int ATTR_W   = 4;

  typedef struct packed {
    logic [PPN_W-1:0]  ppn;
    logic [AP_W-1:0]   ap;
    logic [DOM_W-1:0]  dom;
    logic [ATTR_W-1:0] attr;
  } xlat_desc_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_FILL = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/rr_tlb_cam.sv
module rr_tlb_cam
  import rr_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  xlat_desc_t         wr_desc,
  input  logic               inv_all,
  input  logic [IDX_W-1:0]   lock_base,
  output logic               hit,
  output logic [ENTRIES-1:0] hit_vec,
  output xlat_desc_t         hit_desc
);
  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  xlat_desc_t         desc_q [ENTRIES];

  // Entry storage: a fill write wins over a same-cycle invalidate of its slot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_en && (wr_idx == IDX_W'(i))) begin
          valid_q[i] <= 1'b1;
        end else if (inv_all && (IDX_W'(i) >= lock_base)) begin
          valid_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        vpn_q[i]  <= wr_vpn;
        desc_q[i] <= wr_desc;
      end
    end
  end

  // Parallel comparators, one per entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
  end

  assign hit = |hit_vec;

  // At most one entry matches, so an OR mux selects the descriptor.
  always_comb begin
    hit_desc = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_desc = hit_desc | desc_q[i];
    end
  end
endmodule

// File: rtl/rr_tlb_victim.sv
module rr_tlb_victim #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int LCK_W   = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_wr,
  input  logic [LCK_W-1:0] lock_val,
  input  logic             advance,
  output logic [IDX_W-1:0] victim_idx,
  output logic [IDX_W-1:0] lock_base
);
  localparam int LAST = ENTRIES - 1;

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] base_q;

  // The boundary saturates one below the entry count, so the last entry stays free.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (lock_wr) begin
      if (lock_val > LCK_W'(LAST)) base_q <= IDX_W'(LAST);
      else                         base_q <= lock_val[IDX_W-1:0];
    end
  end

  // A pointer left below a newly raised boundary is lifted to it.
  assign victim_idx = (ptr_q < base_q) ? base_q : ptr_q;
  assign lock_base  = base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (advance) begin
      if (victim_idx == IDX_W'(LAST)) ptr_q <= base_q;
      else                            ptr_q <= victim_idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/rr_tlb_ctrl.sv
module rr_tlb_ctrl
  import rr_tlb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lk_valid,
  input  logic lk_hit,
  input  logic rsp_valid,
  input  logic rsp_ready,
  input  logic walk_req_ready,
  input  logic fill_valid,
  output logic lk_ready,
  output logic lk_accept,
  output logic walk_req_valid,
  output logic fill_ready,
  output logic fill_take,
  output logic miss
);
  ctl_state_e state_q, state_d;

  assign lk_ready       = (state_q == ST_IDLE) && (!rsp_valid || rsp_ready);
  assign lk_accept      = lk_valid && lk_ready;
  assign walk_req_valid = (state_q == ST_WALK);
  assign fill_ready     = (state_q == ST_FILL);
  assign fill_take      = fill_valid && fill_ready;
  assign miss           = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (lk_accept && !lk_hit) state_d = ST_WALK;
      ST_WALK: if (walk_req_ready)       state_d = ST_FILL;
      ST_FILL: if (fill_valid)           state_d = ST_IDLE;
      default:                           state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/rr_tlb.sv
module rr_tlb
  import rr_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int LCK_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [AP_W-1:0]   rsp_ap,
  output logic [DOM_W-1:0]  rsp_dom,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic              miss,
  output logic              walk_req_valid,
  input  logic              walk_req_ready,
  output logic [VPN_W-1:0]  walk_req_vpn,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [AP_W-1:0]   fill_ap,
  input  logic [DOM_W-1:0]  fill_dom,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic              lock_wr,
  input  logic [LCK_W-1:0]  lock_val,
  input  logic              inv_all
);
  logic               lk_hit;
  logic [ENTRIES-1:0] hit_vec;
  xlat_desc_t         hit_desc;
  xlat_desc_t         fill_desc;
  logic               lk_accept;
  logic               fill_take;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   lock_base;

  logic [VPN_W-1:0]    pend_vpn_q;
  logic [PG_OFS_W-1:0] pend_ofs_q;
  xlat_desc_t          rsp_desc_q;
  logic [PG_OFS_W-1:0] rsp_ofs_q;
  logic                rsp_valid_q;
  logic                rsp_hit_q;

  assign fill_desc = '{ppn: fill_ppn, ap: fill_ap, dom: fill_dom, attr: fill_attr};

  rr_tlb_cam #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_vpn    (lk_vaddr[VA_W-1:PG_OFS_W]),
    .wr_en     (fill_take),
    .wr_idx    (victim_idx),
    .wr_vpn    (pend_vpn_q),
    .wr_desc   (fill_desc),
    .inv_all   (inv_all),
    .lock_base (lock_base),
    .hit       (lk_hit),
    .hit_vec   (hit_vec),
    .hit_desc  (hit_desc)
  );

  rr_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .LCK_W(LCK_W)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_wr    (lock_wr),
    .lock_val   (lock_val),
    .advance    (fill_take),
    .victim_idx (victim_idx),
    .lock_base  (lock_base)
  );

  rr_tlb_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid       (lk_valid),
    .lk_hit         (lk_hit),
    .rsp_valid      (rsp_valid_q),
    .rsp_ready      (rsp_ready),
    .walk_req_ready (walk_req_ready),
    .fill_valid     (fill_valid),
    .lk_ready       (lk_ready),
    .lk_accept      (lk_accept),
    .walk_req_valid (walk_req_valid),
    .fill_ready     (fill_ready),
    .fill_take      (fill_take),
    .miss           (miss)
  );

  // Address of the stalled lookup, held for the walk and the fill write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vpn_q <= '0;
      pend_ofs_q <= '0;
    end else if (lk_accept && !lk_hit) begin
      pend_vpn_q <= lk_vaddr[VA_W-1:PG_OFS_W];
      pend_ofs_q <= lk_vaddr[PG_OFS_W-1:0];
    end
  end

  assign walk_req_vpn = pend_vpn_q;

  // Single-entry response slot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_desc_q  <= '0;
      rsp_ofs_q   <= '0;
    end else if (lk_accept && lk_hit) begin
      rsp_valid_q <= 1'b1;
      rsp_hit_q   <= 1'b1;
      rsp_desc_q  <= hit_desc;
      rsp_ofs_q   <= lk_vaddr[PG_OFS_W-1:0];
    end else if (fill_take) begin
      rsp_valid_q <= 1'b1;
      rsp_hit_q   <= 1'b0;
      rsp_desc_q  <= fill_desc;
      rsp_ofs_q   <= pend_ofs_q;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_paddr = {rsp_desc_q.ppn, rsp_ofs_q};
  assign rsp_ap    = rsp_desc_q.ap;
  assign rsp_dom   = rsp_desc_q.dom;
  assign rsp_attr  = rsp_desc_q.attr;
endmodule

// File: rtl/rr_tlb_chk.sv
module rr_tlb_chk
  import rr_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_ready,
  input logic               miss,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic               rsp_hit,
  input logic               walk_req_valid,
  input logic               walk_req_ready,
  input logic [VPN_W-1:0]   walk_req_vpn,
  input logic               fill_ready,
  input logic               fill_valid,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [IDX_W-1:0]   victim_idx,
  input logic [IDX_W-1:0]   lock_base
);
  // R2: never more than one matching entry
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R3: no new lookup is taken while a walk is outstanding
  p_stall_on_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> !lk_ready);

  // R3: a stalled walk request keeps its page number
  p_walk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_req_ready) |=> (walk_req_valid && $stable(walk_req_vpn)));

  // R4: a taken fill ends the miss and yields a walk-served response
  p_fill_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> (rsp_valid && !rsp_hit && !miss));

  // R6: the victim is never a locked entry
  p_victim_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    victim_idx >= lock_base);

  // R9: a blocked response holds
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_hit)));
endmodule

bind rr_tlb rr_tlb_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_rr_tlb_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .lk_ready       (lk_ready),
  .miss           (miss),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_paddr      (rsp_paddr),
  .rsp_hit        (rsp_hit),
  .walk_req_valid (walk_req_valid),
  .walk_req_ready (walk_req_ready),
  .walk_req_vpn   (walk_req_vpn),
  .fill_ready     (fill_ready),
  .fill_valid     (fill_valid),
  .hit_vec        (hit_vec),
  .victim_idx     (victim_idx),
  .lock_base      (lock_base)
);

// File: tb/test_rr_tlb.sv
module test_rr_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_ap;
  logic [3:0]  rsp_dom;
  logic [3:0]  rsp_attr;
  logic        miss;
  logic        walk_req_valid;
  logic        walk_req_ready = 1'b0;
  logic [19:0] walk_req_vpn;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [19:0] fill_ppn = '0;
  logic [1:0]  fill_ap = '0;
  logic [3:0]  fill_dom = '0;
  logic [3:0]  fill_attr = '0;
  logic        lock_wr = 1'b0;
  logic [5:0]  lock_val = '0;
  logic        inv_all = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rr_tlb i_rr_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_vaddr(lk_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_paddr(rsp_paddr), .rsp_ap(rsp_ap), .rsp_dom(rsp_dom), .rsp_attr(rsp_attr),
    .miss(miss), .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
    .walk_req_vpn(walk_req_vpn), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_ppn(fill_ppn), .fill_ap(fill_ap), .fill_dom(fill_dom), .fill_attr(fill_attr),
    .lock_wr(lock_wr), .lock_val(lock_val), .inv_all(inv_all)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Walker model: descriptor derived from the page number.
  function automatic logic [29:0] desc_of(input logic [19:0] vpn);
    return {vpn ^ 20'hC3A5F, vpn[1:0] ^ 2'b11, vpn[5:2], vpn[9:6] ^ 4'h9};
  endfunction

  function automatic logic [41:0] exp_rsp(input logic [31:0] va);
    logic [29:0] d = desc_of(va[31:12]);
    return {d[29:10], va[11:0], d[9:0]};
  endfunction

  function automatic logic [41:0] got_rsp();
    return {rsp_paddr, rsp_ap, rsp_dom, rsp_attr};
  endfunction

  function automatic logic [31:0] va_of(input int grp, input int i);
    return {4'(grp), 16'(i * 37 + 5), 12'(i * 13 + 1)};
  endfunction

  // One lookup; serves a walk if one is raised, holding the walker off walk_dly cycles.
  task automatic lookup(input logic [31:0] va, input bit exp_hit, input string req, input int walk_dly = 0);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = va;
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_valid == exp_hit, req, 64'(rsp_valid), 64'(exp_hit));
    if (rsp_valid) begin
      chk(rsp_hit && got_rsp() == exp_rsp(va), "R2 hit fields", 64'(got_rsp()), 64'(exp_rsp(va)));
    end else if (walk_req_valid) begin
      chk(miss && !lk_ready && walk_req_vpn == va[31:12], "R3 walk request",
          64'(walk_req_vpn), 64'(va[31:12]));
      for (int k = 0; k < walk_dly; k++) begin
        @(negedge clk);
        chk(walk_req_valid && !fill_ready && walk_req_vpn == va[31:12], "R3 walk held",
            64'(walk_req_vpn), 64'(va[31:12]));
      end
      walk_req_ready = 1'b1;
      @(negedge clk);
      walk_req_ready = 1'b0;
      chk(fill_ready && miss && !walk_req_valid && !lk_ready, "R4 fill_ready", 64'(fill_ready), 64'd1);
      {fill_ppn, fill_ap, fill_dom, fill_attr} = desc_of(va[31:12]);
      fill_valid = 1'b1;
      @(negedge clk);
      fill_valid = 1'b0;
      chk(rsp_valid && !rsp_hit && !miss, "R4 fill response", 64'({rsp_valid, rsp_hit, miss}), 64'b100);
      chk(got_rsp() == exp_rsp(va), "R4 fill fields", 64'(got_rsp()), 64'(exp_rsp(va)));
    end else begin
      chk(1'b0, "R3 no walk raised", 64'(walk_req_valid), 64'd1);
    end
  endtask

  task automatic pulse_lock(input logic [5:0] v);
    @(negedge clk);
    lock_wr = 1'b1;
    lock_val = v;
    @(negedge clk);
    lock_wr = 1'b0;
  endtask

  task automatic pulse_inv();
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
  endtask

  task automatic t_reset();
    chk(lk_ready && !miss && !rsp_valid && !walk_req_valid && !fill_ready, "R1 reset outputs",
        64'({lk_ready, miss, rsp_valid, walk_req_valid, fill_ready}), 64'b10000);
  endtask

  // R5: 32 fills fill the array; the 33rd evicts the first.
  task automatic t_round_robin();
    for (int i = 0; i < 32; i++) lookup(va_of(1, i), 1'b0, "R5 cold fill", (i == 0) ? 2 : 0);
    lookup(va_of(1, 5), 1'b1, "R4 installed entry hits");
    lookup(va_of(1, 32), 1'b0, "R5 33rd fill");
    lookup(va_of(1, 2), 1'b1, "R5 entry 2 kept");
    lookup(va_of(1, 31), 1'b1, "R5 entry 31 kept");
    lookup(va_of(1, 0), 1'b0, "R5 first fill evicted");
  endtask

  // R9: blocked response holds and stalls new lookups.
  task automatic t_backpressure();
    logic [41:0] held;
    @(negedge clk);
    rsp_ready = 1'b0;
    lk_valid = 1'b1;
    lk_vaddr = va_of(1, 2);
    @(negedge clk);
    lk_valid = 1'b0;
    held = got_rsp();
    chk(rsp_valid && rsp_hit && held == exp_rsp(va_of(1, 2)), "R9 response", 64'(held), 64'(exp_rsp(va_of(1, 2))));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && !lk_ready && got_rsp() == held, "R9 hold", 64'(got_rsp()), 64'(held));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && lk_ready, "R9 drained", 64'({rsp_valid, lk_ready}), 64'b01);
  endtask

  // Entries 0..2 now hold groups 1:32, 1:0, 1:2; pointer sits at 2.
  task automatic t_lock_and_inv();
    pulse_lock(6'd3);
    pulse_inv();
    lookup(va_of(1, 32), 1'b1, "R8 locked entry 0 survives");
    lookup(va_of(1, 0), 1'b1, "R8 locked entry 1 survives");
    lookup(va_of(1, 2), 1'b1, "R8 locked entry 2 survives");
    lookup(va_of(1, 31), 1'b0, "R8 unlocked entry cleared");
    for (int i = 4; i < 32; i++) lookup(va_of(2, i), 1'b0, "R6 fill above boundary");
    lookup(va_of(3, 0), 1'b0, "R6 wrap fill");
    lookup(va_of(1, 32), 1'b1, "R6 locked entry 0 kept");
    lookup(va_of(1, 0), 1'b1, "R6 locked entry 1 kept");
    lookup(va_of(1, 2), 1'b1, "R6 locked entry 2 kept");
    lookup(va_of(1, 31), 1'b0, "R6 wrap went to boundary");
  endtask

  // R7: saturated lock leaves only entry 31.
  task automatic t_lock_clamp();
    pulse_lock(6'd63);
    lookup(va_of(4, 1), 1'b0, "R7 fill into last");
    lookup(va_of(4, 2), 1'b0, "R7 second fill into last");
    lookup(va_of(2, 30), 1'b1, "R7 entry 30 kept");
    lookup(va_of(4, 1), 1'b0, "R7 last entry replaced");
    pulse_inv();
    lookup(va_of(2, 30), 1'b1, "R8 entry 30 locked survives");
    lookup(va_of(4, 2), 1'b0, "R8 last entry cleared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_round_robin();
    t_backpressure();
    t_lock_and_inv();
    t_lock_clamp();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule